// File: doc/BRIEF.md
# Clock-Mode Switch Guard

This block holds the clock-source configuration of a microcontroller core: a two-bit divide code, the multiplier enable bit, and the multiplier ratio select (times four or times two). Software writes each field through its own write strobe with data. The block commits a write only when the resulting change obeys the glitch-free switching rules. A write that breaks those rules is dropped without effect and raises a one-cycle reject pulse. The committed bits feed the clock dividers and the multiplier, which lie outside this block.

The divide code has four values. 00 runs from the frequency multiplier. 01 is reserved. 10 divides by four and is the reset value. 11 is the slow power-saving divide. Every move between 00 and 11 must pass through 10. Entering 00 is guarded by an ordered unlock, carried out while the code is 10 and the alternate-oscillator flag is low. The steps are: clear the enable, write the ratio select, set the enable, then wait until the ready flag reads 1. The ready flag comes from a lock timer of `LOCK_CYCLES` clocks, which runs while the enable is set and the multiplier lock input is high. Writes that touch no step may fall between the steps. Any out-of-order step sends the unlock back to its start.

Top module: `clkmode_guard`

## Requirements
- R1: After reset, div_code is 10, mul_en is 0, mul_x4 is 0, mul_ready is 0 and wr_reject is 0.
- R2: A divide write with data 01 is always rejected, and div_code keeps its value.
- R3: A divide write from 00 to 11, or from 11 to 00, is rejected. Writes of 10 from any code, and of 11 from 10, are accepted. Rewriting the current code is accepted and changes nothing.
- R4: A write of 00 while the code is 10 is accepted only when the unlock is complete. That means the enable cleared, then a ratio write, then the enable set, then mul_ready at 1, with alt_mode low. div_code takes 00 on the clock edge that samples the accepted write.
- R5: The unlock restarts from its beginning in each of these cases: the enable is set other than directly after a ratio step; a ratio write comes before the enable was cleared; alt_mode is 1; or the code leaves 10. Writing the enable to 0 always restarts it at the "cleared" step. After a restart, a write of 00 is rejected unless the steps are repeated in order.
- R6: Divide writes of 10 and rejected writes falling between unlock steps do not disturb the unlock.
- R7: mul_ready becomes 1 exactly LOCK_CYCLES clocks after mul_en reads 1, provided lock_in stays 1. It returns to 0 one clock after mul_en or lock_in reads 0.
- R8: While div_code is 00, a write clearing the enable and any ratio write are rejected, and mul_en and mul_x4 keep their values.
- R9: wr_reject is 1 for exactly the one cycle after each rejected write and stays 0 after accepted writes. mul_x4 holds the last accepted ratio write (1 = times four).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_div | input | 1 | Divide-code write strobe |
| wr_div_data | input | 2 | Requested divide code |
| wr_en | input | 1 | Multiplier-enable write strobe |
| wr_en_data | input | 1 | Requested enable value |
| wr_ratio | input | 1 | Ratio-select write strobe |
| wr_ratio_data | input | 1 | Requested ratio (1 = times four) |
| alt_mode | input | 1 | Alternate oscillator active; blocks the unlock |
| lock_in | input | 1 | Lock indication from the multiplier model |
| div_code | output | 2 | Committed divide code |
| mul_en | output | 1 | Committed multiplier enable |
| mul_x4 | output | 1 | Committed ratio select |
| mul_ready | output | 1 | Lock timer expired while enabled |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest state to reach from the ports is the point where the unlock is complete and ready is up. The bench walks through every step of the unlock, with a shortened lock time, before it offers a 00 write. It then breaks that path one step at a time: the first step left out, the ratio step left out, an early 00 write, a pulse on alt_mode, a detour through 11, and lock held low. Each time it checks that the later 00 write is refused. The divide-code transition matrix is swept exhaustively from every reachable code, and the expected legality is computed arithmetically.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam logic [1:0] DIV_MULT    = 2'b00;
  localparam logic [1:0] DIV_RSVD    = 2'b01;
  localparam logic [1:0] DIV_QUARTER = 2'b10;
  localparam logic [1:0] DIV_SLOW    = 2'b11;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_CLEARED  = 2'd1,
    SEQ_SELECTED = 2'd2,
    SEQ_ARMED    = 2'd3
  } seq_t;

  // Legality of a divide-code move; unlock_ok gates entry to the multiplier.
  function automatic logic div_move_ok(input logic [1:0] cur,
                                       input logic [1:0] req,
                                       input logic       unlock_ok);
    logic ok;
    case (req)
      DIV_RSVD:    ok = 1'b0;
      DIV_MULT:    ok = (cur == DIV_MULT) || ((cur == DIV_QUARTER) && unlock_ok);
      DIV_SLOW:    ok = (cur != DIV_MULT);
      default:     ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/clkmode_lock_timer.sv
module clkmode_lock_timer #(
  parameter int LOCK_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic lock_in,
  output logic ready
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          run;

  assign run = enable && lock_in;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      ready <= (cnt_q == LAST) || (cnt_q == FULL);
    end
  end

  // R7: ready only once the full count has elapsed
  p_ready_full_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cnt_q == FULL));
  // R7: dropping the enable removes ready on the next clock
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !ready);

endmodule

// File: rtl/clkmode_unlock_fsm.sv
module clkmode_unlock_fsm
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_code,
  input  logic       alt_mode,
  input  logic       en_wr,
  input  logic       en_data,
  input  logic       ratio_wr,
  output logic       armed
);
  seq_t state_q, state_d;
  logic eligible;

  assign eligible = (div_code == DIV_QUARTER) && !alt_mode;

  always_comb begin
    state_d = state_q;
    if (!eligible) begin
      state_d = SEQ_IDLE;
    end else if (en_wr) begin
      if (!en_data)                     state_d = SEQ_CLEARED;
      else if (state_q == SEQ_SELECTED) state_d = SEQ_ARMED;
      else                              state_d = SEQ_IDLE;
    end else if (ratio_wr) begin
      if (state_q == SEQ_CLEARED || state_q == SEQ_SELECTED) state_d = SEQ_SELECTED;
      else                                                    state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  assign armed = (state_q == SEQ_ARMED);

  // R5: the armed step is reached only through the ratio step
  p_armed_order_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q != SEQ_SELECTED && state_q != SEQ_ARMED) |=> (state_q != SEQ_ARMED));
  // R5: alternate oscillator forces a restart
  p_alt_restart_r5: assert property (@(posedge clk) disable iff (rst)
    alt_mode |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/clkmode_guard.sv
module clkmode_guard
  import clkmode_pkg::*;
#(
  parameter int LOCK_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_div,
  input  logic [1:0] wr_div_data,
  input  logic       wr_en,
  input  logic       wr_en_data,
  input  logic       wr_ratio,
  input  logic       wr_ratio_data,
  input  logic       alt_mode,
  input  logic       lock_in,
  output logic [1:0] div_code,
  output logic       mul_en,
  output logic       mul_x4,
  output logic       mul_ready,
  output logic       wr_reject
);
  logic armed;
  logic unlock_ok;
  logic div_ok, en_ok, ratio_ok;
  logic reject_d;

  assign unlock_ok = armed && mul_ready && !alt_mode;
  assign div_ok    = wr_div   && div_move_ok(div_code, wr_div_data, unlock_ok);
  assign en_ok     = wr_en    && !((div_code == DIV_MULT) && !wr_en_data);
  assign ratio_ok  = wr_ratio && (div_code != DIV_MULT);
  assign reject_d  = (wr_div && !div_ok) || (wr_en && !en_ok) || (wr_ratio && !ratio_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_code  <= DIV_QUARTER;
      mul_en    <= 1'b0;
      mul_x4    <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      if (div_ok)   div_code <= wr_div_data;
      if (en_ok)    mul_en   <= wr_en_data;
      if (ratio_ok) mul_x4   <= wr_ratio_data;
      wr_reject <= reject_d;
    end
  end

  clkmode_unlock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .div_code (div_code),
    .alt_mode (alt_mode),
    .en_wr    (en_ok),
    .en_data  (wr_en_data),
    .ratio_wr (ratio_ok),
    .armed    (armed)
  );

  clkmode_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .enable  (mul_en),
    .lock_in (lock_in),
    .ready   (mul_ready)
  );

  // R2: reserved code never committed
  p_no_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    div_code != DIV_RSVD);
  // R2: a reserved write is flagged
  p_reserved_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_div && wr_div_data == DIV_RSVD) |=> wr_reject);
  // R3: no direct hop from multiplier to slow
  p_no_hop_up_r3: assert property (@(posedge clk) disable iff (rst)
    (div_code == DIV_MULT) |=> (div_code != DIV_SLOW));
  // R3: no direct hop from slow to multiplier
  p_no_hop_down_r3: assert property (@(posedge clk) disable iff (rst)
    (div_code == DIV_SLOW) |=> (div_code != DIV_MULT));
  // R4: multiplier entry needs ready
  p_entry_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (div_code == DIV_QUARTER && !mul_ready) |=> (div_code != DIV_MULT));
  // R4: multiplier entry blocked by alternate oscillator
  p_entry_alt_r4: assert property (@(posedge clk) disable iff (rst)
    (div_code == DIV_QUARTER && alt_mode) |=> (div_code != DIV_MULT));
  // R8: enable cannot be cleared while running on the multiplier
  p_hold_en_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_en_data && div_code == DIV_MULT && mul_en) |=> (mul_en && wr_reject));
  // R8: ratio frozen while running on the multiplier
  p_hold_ratio_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ratio && div_code == DIV_MULT) |=> ($stable(mul_x4) && wr_reject));

endmodule

// File: tb/clkmode_guard_tb.sv
module clkmode_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_div = 1'b0;
  logic [1:0] wr_div_data = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_en_data = 1'b0;
  logic       wr_ratio = 1'b0;
  logic       wr_ratio_data = 1'b0;
  logic       alt_mode = 1'b0;
  logic       lock_in = 1'b1;
  logic [1:0] div_code;
  logic       mul_en, mul_x4, mul_ready, wr_reject;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmode_guard #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst(rst),
    .wr_div(wr_div), .wr_div_data(wr_div_data),
    .wr_en(wr_en), .wr_en_data(wr_en_data),
    .wr_ratio(wr_ratio), .wr_ratio_data(wr_ratio_data),
    .alt_mode(alt_mode), .lock_in(lock_in),
    .div_code(div_code), .mul_en(mul_en), .mul_x4(mul_x4),
    .mul_ready(mul_ready), .wr_reject(wr_reject)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Each write task starts and ends at a falling edge; outputs are settled at return.
  task automatic w_div(input logic [1:0] v);
    wr_div = 1'b1; wr_div_data = v;
    @(negedge clk);
    wr_div = 1'b0;
  endtask

  task automatic w_en(input logic v);
    wr_en = 1'b1; wr_en_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic w_ratio(input logic v);
    wr_ratio = 1'b1; wr_ratio_data = v;
    @(negedge clk);
    wr_ratio = 1'b0;
  endtask

  task automatic wait_lock();
    repeat (LOCK) @(negedge clk);
  endtask

  task automatic go_quarter();
    w_div(2'b10);
    w_en(1'b0);
  endtask

  task automatic go_mult(input logic x4);
    go_quarter();
    w_ratio(x4);
    w_en(1'b1);
    wait_lock();
    w_div(2'b00);
  endtask

  task automatic go_code(input logic [1:0] c);
    if (c == 2'b00) go_mult(1'b1);
    else if (c == 2'b10) go_quarter();
    else begin go_quarter(); w_div(2'b11); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "div_code", div_code, 2);
    chk("R1", "mul_en", mul_en, 0);
    chk("R1", "mul_x4", mul_x4, 0);
    chk("R1", "mul_ready", mul_ready, 0);
    chk("R1", "wr_reject", wr_reject, 0);

    // R2 R3 R9: exhaustive divide transition sweep (no unlock for 10 -> 00)
    for (int f = 0; f < 4; f++) begin
      if (f == 1) continue;
      for (int t = 0; t < 4; t++) begin
        bit legal;
        go_code(2'(f));
        chk("R3", "setup code", div_code, f);
        legal = (t != 1) && !(f == 0 && t == 3) && !(f == 3 && t == 0) && !(f == 2 && t == 0);
        w_div(2'(t));
        chk(t == 1 ? "R2" : "R3", $sformatf("code %0d->%0d", f, t), div_code, legal ? t : f);
        chk("R9", $sformatf("reject %0d->%0d", f, t), wr_reject, legal ? 0 : 1);
        @(negedge clk);
        chk("R9", "reject one cycle", wr_reject, 0);
      end
    end

    // R4 R7 full unlock with x2 ratio, timer timing
    go_quarter();
    w_ratio(1'b0);
    w_en(1'b1);
    chk("R7", "ready low at enable", mul_ready, 0);
    repeat (LOCK - 1) @(negedge clk);
    chk("R7", "ready low at LOCK-1", mul_ready, 0);
    @(negedge clk);
    chk("R7", "ready high at LOCK", mul_ready, 1);
    w_div(2'b00);
    chk("R4", "entry accepted", div_code, 0);
    chk("R9", "no reject on accept", wr_reject, 0);
    chk("R9", "ratio x2", mul_x4, 0);

    // R8 frozen fields in multiplier mode
    w_en(1'b0);
    chk("R8", "enable held", mul_en, 1);
    chk("R8", "enable clear rejected", wr_reject, 1);
    w_ratio(1'b1);
    chk("R8", "ratio held", mul_x4, 0);
    chk("R8", "ratio write rejected", wr_reject, 1);
    w_div(2'b10);
    chk("R3", "00 -> 10 free", div_code, 2);

    // R7 ready drops one clock after enable clear
    w_en(1'b0);
    chk("R7", "ready still up same cycle", mul_ready, 1);
    @(negedge clk);
    chk("R7", "ready cleared", mul_ready, 0);

    // R5 first step skipped
    go_quarter();
    w_en(1'b1);
    w_ratio(1'b1);
    w_en(1'b1);
    wait_lock();
    w_div(2'b00);
    chk("R5", "missing clear", div_code, 2);

    // R5 ratio step skipped
    go_quarter();
    w_en(1'b1);
    wait_lock();
    w_div(2'b00);
    chk("R5", "missing ratio", div_code, 2);

    // R4 early entry rejected, later accepted (state kept); x4 ratio
    go_quarter();
    w_ratio(1'b1);
    w_en(1'b1);
    w_div(2'b00);
    chk("R4", "early entry rejected", div_code, 2);
    chk("R9", "early entry flagged", wr_reject, 1);
    wait_lock();
    w_div(2'b00);
    chk("R4", "entry after ready", div_code, 0);
    chk("R9", "ratio x4", mul_x4, 1);

    // R5 alt_mode pulse breaks the unlock
    go_quarter();
    w_ratio(1'b1);
    w_en(1'b1);
    wait_lock();
    alt_mode = 1'b1;
    @(negedge clk);
    alt_mode = 1'b0;
    @(negedge clk);
    w_div(2'b00);
    chk("R5", "alt_mode restart", div_code, 2);

    // R5 code leaves 10 mid-sequence
    go_quarter();
    w_ratio(1'b1);
    w_div(2'b11);
    w_div(2'b10);
    w_en(1'b1);
    wait_lock();
    w_div(2'b00);
    chk("R5", "code detour", div_code, 2);

    // R7 lock input low keeps ready off
    go_quarter();
    lock_in = 1'b0;
    w_ratio(1'b0);
    w_en(1'b1);
    wait_lock();
    chk("R7", "no ready without lock", mul_ready, 0);
    w_div(2'b00);
    chk("R7", "entry refused without lock", div_code, 2);
    lock_in = 1'b1;

    // R6 unrelated writes between steps
    go_quarter();
    w_div(2'b10);
    w_div(2'b01);
    chk("R6", "interleaved reserved rejected", wr_reject, 1);
    w_ratio(1'b1);
    w_div(2'b10);
    w_en(1'b1);
    w_div(2'b01);
    wait_lock();
    w_div(2'b00);
    chk("R6", "entry after interleaved writes", div_code, 0);

    // R3 same-code rewrite at 00
    w_div(2'b00);
    chk("R3", "rewrite 00", div_code, 0);
    chk("R3", "rewrite no reject", wr_reject, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule